// File: doc/BRIEF.md
# Repeating Status Register Shifter

This block answers the status-read command of a serial slave port. The serial port runs in mode 0: the clock idles low, input bits are sampled on the rising clock edge, and output bits change on the falling edge. The host lowers chip select and clocks in an eight-bit opcode, MSB first. If the opcode is one of the two status-read codes, the block drives an eight-bit status word on the serial output, MSB first, starting on the very next serial clock cycle. The word repeats without a gap for as long as chip select stays low and the clock keeps running.

The word is captured again at the start of every repetition. A host can therefore keep clocking and watch the ready bit until the internal operation engine finishes. The word carries four fields: the ready bit, a sticky compare-mismatch flag written by the compare engine's done strobe, a fixed density code, and two reserved zero bits.

The serial clock, chip select and data input are taken to be synchronous to the system clock and already free of metastability. The block finds serial clock edges by comparing the serial clock with a registered copy of itself. The serial output and its enable are meant to drive a three-state pad.

Top module: `status_rpt_shifter`

## Requirements
- R1: After reset, `sdo_oe` and `sdo` are 0, and the compare flag (status bit 6) is 0 until a compare-done strobe sets it.
- R2: The status read starts only when the 8 opcode bits, sampled MSB first on rising `sclk` while `cs_n` is low, equal 0x57 or 0xD7. Any other opcode leaves `sdo_oe` at 0 for the rest of that chip-select period.
- R3: Bit 7 of the first status word appears on `sdo` after the falling `sclk` edge that follows the 8th opcode rising edge. Every later bit changes on a falling edge, so the host can sample it on the next rising edge.
- R4: Bits go out in order from bit 7 down to bit 0. The next falling edge after bit 0 starts again at bit 7, with no idle cycle, while `cs_n` stays low.
- R5: The word is captured at the falling edge that puts out its bit 7. A change on `busy` during the other seven bits does not affect the word that is being shifted.
- R6: Status bit 7 is 1 when `busy` is 0 (ready) and 0 when `busy` is 1.
- R7: Status bit 6 is the stored compare flag. It takes the value of `cmp_mismatch` in each cycle that `cmp_done` is 1 (1 means at least one bit differed, 0 means the data matched). When `cmp_done` is 0 it holds its value, whatever `cmp_mismatch` does.
- R8: Status bits 5 down to 2 are the density code 0101, and bits 1 and 0 are 0.
- R9: While `cs_n` is high, `sdo_oe` is 0. After `cs_n` rises, no status bit is driven again until a new status opcode has been received.
- R10: Whenever `sdo_oe` is 0, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock (mode 0), synchronous to `clk` |
| sdi | input | 1 | Serial data in, sampled on rising `sclk` |
| busy | input | 1 | Busy indication from the operation engine |
| cmp_done | input | 1 | One-cycle strobe: a compare operation has finished |
| cmp_mismatch | input | 1 | Compare result; valid while `cmp_done` is 1 |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad |

## Verification
The assertions assume that `sclk`, `cs_n` and `sdi` change only between system clock edges. They also assume that each `sclk` level lasts at least one system clock, so that every serial edge shows up as exactly one rise or fall pulse. The stimulus changes every input on the falling system clock edge and holds each `sclk` level for four system clocks. It changes `busy` only just before a falling serial edge, or in the middle of a word in the capture test. `cmp_done` is always a one-cycle strobe, and `cmp_mismatch` is set up before it.

// File: rtl/stsh_pkg.sv
package stsh_pkg;
  localparam int            STAT_W       = 8;
  localparam int            OPC_W        = 8;
  localparam int            DENS_W       = 4;
  localparam logic [7:0]    OPC_STAT_LO  = 8'h57;
  localparam logic [7:0]    OPC_STAT_HI  = 8'hD7;
  localparam logic [3:0]    DENSITY_CODE = 4'b0101;
endpackage

// File: rtl/stsh_rst_sync.sv
module stsh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb chain_n = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/stsh_edge_det.sv
module stsh_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;
  logic sclk_n;

  always_comb sclk_n = sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_n;
  end

  assign rise_o = ~cs_n &  sclk & ~sclk_q;
  assign fall_o = ~cs_n & ~sclk &  sclk_q;

  // R3: an edge pulse is always a single cycle
  p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o || fall_o) |=> !(rise_o || fall_o) || cs_n);
  p_edge_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
endmodule

// File: rtl/stsh_opc_rx.sv
module stsh_opc_rx #(
  parameter int               OPC_W = 8,
  parameter logic [OPC_W-1:0] OPC_A = 8'h57,
  parameter logic [OPC_W-1:0] OPC_B = 8'hD7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rise,
  input  logic sdi,
  output logic sel_o
);
  localparam int               CNT_W    = $clog2(OPC_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OPC_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OPC_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [OPC_W-1:0] sr_q, sr_n;
  logic             sel_q, sel_n;
  logic             take;
  logic             hit;

  always_comb begin
    take  = rise && (cnt_q != CNT_FULL);
    cnt_n = cnt_q;
    sr_n  = sr_q;
    sel_n = sel_q;
    hit   = 1'b0;
    if (cs_n) begin
      cnt_n = '0;
      sr_n  = '0;
      sel_n = 1'b0;
    end else if (take) begin
      sr_n  = {sr_q[OPC_W-2:0], sdi};
      cnt_n = cnt_q + CNT_W'(1);
      hit   = (cnt_q == CNT_LAST) && ((sr_n == OPC_A) || (sr_n == OPC_B));
      sel_n = sel_q | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
      sel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      sr_q  <= sr_n;
      sel_q <= sel_n;
    end
  end

  assign sel_o = sel_q;

  // R2: the selection appears only once the full opcode has arrived
  p_sel_after_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> (cnt_q == CNT_FULL));
  p_sel_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> ((sr_q == OPC_A) || (sr_q == OPC_B)));
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R9: chip select high clears the selection
  p_sel_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sel_q);
endmodule

// File: rtl/stsh_word_build.sv
module stsh_word_build #(
  parameter int               STAT_W  = 8,
  parameter int               DENS_W  = 4,
  parameter logic [DENS_W-1:0] DENSITY = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              cmp_done,
  input  logic              cmp_mismatch,
  output logic [STAT_W-1:0] word_o
);
  localparam int RSV_W = STAT_W - 2 - DENS_W;

  logic cmp_q, cmp_n;

  always_comb begin
    cmp_n = cmp_q;
    if (cmp_done) cmp_n = cmp_mismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= 1'b0;
    else        cmp_q <= cmp_n;
  end

  generate
    if (RSV_W > 0) begin : g_rsv
      assign word_o = {~busy, cmp_q, DENSITY, {RSV_W{1'b0}}};
    end else begin : g_norsv
      assign word_o = {~busy, cmp_q, DENSITY};
    end
  endgenerate

  // R7: the flag holds without a strobe and follows the mismatch with one
  p_cmp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_done |=> $stable(cmp_q));
  p_cmp_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_done |=> (cmp_q == $past(cmp_mismatch)));
endmodule

// File: rtl/stsh_shifter.sv
module stsh_shifter #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              fall,
  input  logic              sel,
  input  logic [STAT_W-1:0] word,
  output logic              sdo_o,
  output logic              oe_o
);
  localparam int              PH_W    = $clog2(STAT_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STAT_W - 1);

  logic [STAT_W-1:0] sr_q, sr_n;
  logic [PH_W-1:0]   ph_q, ph_n;
  logic              act_q, act_n;
  logic              step;

  always_comb begin
    step  = fall && sel;
    sr_n  = sr_q;
    ph_n  = ph_q;
    act_n = act_q;
    if (cs_n) begin
      sr_n  = '0;
      ph_n  = '0;
      act_n = 1'b0;
    end else if (step) begin
      act_n = 1'b1;
      sr_n  = (ph_q == '0) ? word : {sr_q[STAT_W-2:0], 1'b0};
      ph_n  = (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      ph_q  <= '0;
      act_q <= 1'b0;
    end else begin
      sr_q  <= sr_n;
      ph_q  <= ph_n;
      act_q <= act_n;
    end
  end

  assign oe_o  = act_q & ~cs_n;
  assign sdo_o = oe_o & sr_q[STAT_W-1];

  // R3: output starts only on a falling edge once the opcode selects it
  p_start_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> ($past(fall) && $past(sel)));
  // R4, R5: data moves only on falling edges
  p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !cs_n) |=> $stable(sr_q));
  // R9: chip select high drops the output state
  p_drop_on_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !act_q);
  // R10: a disabled output stays low
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> !sdo_o);
endmodule

// File: rtl/status_rpt_shifter.sv
module status_rpt_shifter
  import stsh_pkg::*;
#(
  parameter int                STAT_BITS = STAT_W,
  parameter int                OPC_BITS  = OPC_W,
  parameter int                DENS_BITS = DENS_W,
  parameter logic [OPC_W-1:0]  OPC_A     = OPC_STAT_LO,
  parameter logic [OPC_W-1:0]  OPC_B     = OPC_STAT_HI,
  parameter logic [DENS_W-1:0] DENSITY   = DENSITY_CODE,
  parameter int                RST_SYNC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  input  logic busy,
  input  logic cmp_done,
  input  logic cmp_mismatch,
  output logic sdo,
  output logic sdo_oe
);
  logic                 rst_i_n;
  logic                 rise;
  logic                 fall;
  logic                 sel;
  logic [STAT_BITS-1:0] word;

  stsh_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  stsh_edge_det u_edge (
    .clk(clk), .rst_n(rst_i_n), .cs_n(cs_n), .sclk(sclk),
    .rise_o(rise), .fall_o(fall)
  );

  stsh_opc_rx #(.OPC_W(OPC_BITS), .OPC_A(OPC_A), .OPC_B(OPC_B)) u_opc (
    .clk(clk), .rst_n(rst_i_n), .cs_n(cs_n), .rise(rise), .sdi(sdi),
    .sel_o(sel)
  );

  stsh_word_build #(.STAT_W(STAT_BITS), .DENS_W(DENS_BITS), .DENSITY(DENSITY)) u_word (
    .clk(clk), .rst_n(rst_i_n), .busy(busy), .cmp_done(cmp_done),
    .cmp_mismatch(cmp_mismatch), .word_o(word)
  );

  stsh_shifter #(.STAT_W(STAT_BITS)) u_shift (
    .clk(clk), .rst_n(rst_i_n), .cs_n(cs_n), .fall(fall), .sel(sel),
    .word(word), .sdo_o(sdo), .oe_o(sdo_oe)
  );

  // R2: no output unless the status opcode was received
  p_oe_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    sdo_oe |-> sel);
  // R9: chip select high keeps the pad released
  p_oe_off_cs_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    cs_n |-> !sdo_oe);
endmodule

// File: tb/status_rpt_shifter_tb_top.sv
module status_rpt_shifter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic busy = 1'b0;
  logic cmp_done = 1'b0;
  logic cmp_mismatch = 1'b0;
  logic sdo;
  logic sdo_oe;

  int n_tests = 0;
  int n_fail  = 0;
  logic cmp_exp = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  status_rpt_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .busy(busy), .cmp_done(cmp_done), .cmp_mismatch(cmp_mismatch),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] stat_of(input logic b, input logic c);
    return {~b, c, 4'b0101, 2'b00};
  endfunction

  // monitor: compare each received word against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        logic [7:0] g;
        g = got_q.pop_front();
        if (exp_q.size() == 0) chk(1'b0, "R4 extra word", {24'd0, g}, 32'd0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(g == e, t, {24'd0, g}, {24'd0, e});
        end
      end
    end
  end

  // driver: opcode, then nbytes status words; busy for word j is pat[j]
  task automatic stat_xact(input logic [7:0] opc, input int nbytes, input logic [7:0] pat,
                           input bit toggle, input string tag);
    logic [7:0] rx = '0;
    bit oe_bad = 1'b0;
    cs_n = 1'b0;
    hp();
    for (int k = 0; k < 8 + 8 * nbytes; k++) begin
      sdi = (k < 8) ? opc[7 - k] : 1'b0;
      hp();
      if (k >= 8) begin
        rx = {rx[6:0], sdo};
        if (!sdo_oe) oe_bad = 1'b1;
        if ((k - 8) % 8 == 7) got_q.push_back(rx);
      end
      sclk = 1'b1;
      hp();
      if ((k % 8 == 7) && ((k + 1) / 8 - 1 < nbytes)) begin
        int j;
        j = (k + 1) / 8 - 1;
        busy = pat[j];
        exp_q.push_back(stat_of(pat[j], cmp_exp));
        tag_q.push_back(tag);
      end
      if (toggle && k >= 8 && (k % 8 == 3)) busy = ~busy;
      sclk = 1'b0;
    end
    chk(!oe_bad, "R3 sdo_oe during status", {31'd0, oe_bad}, 32'd0);
    hp();
    cs_n = 1'b1;
    #1;
    chk(sdo_oe == 1'b0, "R9 oe after cs_n high", {31'd0, sdo_oe}, 32'd0);
    chk(sdo == 1'b0, "R10 sdo when released", {31'd0, sdo}, 32'd0);
    hp();
  endtask

  task automatic other_xact(input logic [7:0] opc);
    bit oe_seen = 1'b0;
    cs_n = 1'b0;
    hp();
    for (int k = 0; k < 24; k++) begin
      sdi = (k < 8) ? opc[7 - k] : 1'b1;
      hp();
      if (sdo_oe || sdo) oe_seen = 1'b1;
      sclk = 1'b1;
      hp();
      sclk = 1'b0;
    end
    hp();
    chk(!oe_seen, "R2 non-status opcode", {31'd0, oe_seen}, 32'd0);
    cs_n = 1'b1;
    hp();
  endtask

  task automatic pulse_cmp(input logic mis);
    cmp_mismatch = mis;
    cmp_done = 1'b1;
    @(negedge clk);
    cmp_done = 1'b0;
    cmp_exp = mis;
    @(negedge clk);
  endtask

  task automatic finish_up();
    wait (got_q.size() == 0);
    @(negedge clk);
    if (exp_q.size() != 0) chk(1'b0, "R4 missing words", exp_q.size(), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sdo_oe == 1'b0, "R1 oe in reset", {31'd0, sdo_oe}, 32'd0);
    chk(sdo == 1'b0, "R1 sdo in reset", {31'd0, sdo}, 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(sdo_oe == 1'b0, "R1 oe after reset", {31'd0, sdo_oe}, 32'd0);

    // R1 R6 R8: ready word with flag 0 after reset
    stat_xact(8'h57, 1, 8'b0000_0000, 1'b0, "R1 R6 R8 first word");
    // R3 R4 R6: repeating words with alternating busy
    stat_xact(8'h57, 4, 8'b0000_0110, 1'b0, "R3 R4 R6 repeat");
    // R2 R7: alternate opcode after a mismatch compare
    pulse_cmp(1'b1);
    stat_xact(8'hD7, 2, 8'b0000_0001, 1'b0, "R2 R7 mismatch flag");
    // R7: mismatch input moves without a strobe, flag holds
    cmp_mismatch = 1'b0;
    repeat (3) @(negedge clk);
    stat_xact(8'h57, 1, 8'b0000_0000, 1'b0, "R7 flag held");
    // R5: busy flips mid-word; each word keeps its captured value
    stat_xact(8'h57, 4, 8'b0000_0101, 1'b1, "R5 capture per word");
    busy = 1'b0;
    // R7: match strobe clears the flag
    pulse_cmp(1'b0);
    stat_xact(8'hD7, 2, 8'b0000_0010, 1'b0, "R7 match clears");
    // R2: other opcodes give no output
    other_xact(8'h52);
    other_xact(8'h56);
    other_xact(8'h77);
    // R9: a new chip-select period needs a new opcode
    stat_xact(8'h57, 1, 8'b0000_0001, 1'b0, "R9 fresh opcode");
    // R1: reset clears the flag
    pulse_cmp(1'b1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cmp_exp = 1'b0;
    repeat (6) @(negedge clk);
    stat_xact(8'h57, 1, 8'b0000_0000, 1'b0, "R1 flag cleared by reset");
    finish_up();
  end
endmodule